// File: doc/BRIEF.md
# Flag Offset Register Sequencer

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Each offset is kept as two bytes, so there are four byte registers in all. Software or a host loads them through the FIFO's own data input. While the load pin and the write enable are both held low, each rising write-clock edge stores the low byte of the data input into the next register of a fixed cycle and moves a pointer on.

On the read side, the same four bytes can be returned one at a time on a readback output. A second pointer steps through the same cycle on the read clock. The two offsets go to the flag logic as continuous outputs. Each offset is its high byte placed above its low byte, cut down to the address width that the FIFO depth needs.

Top module: `flag_offset_seq`

## Requirements
- R1: While rst_ni is low and after it is released, empty_ofs_o and full_ofs_o both equal 7 (low bytes 7, high bytes 0), and rb_byte_o is 0.
- R2: On a rising wr_clk_i with load_n_i and wr_en_n_i both low, the register under the load pointer takes data_i[7:0], and the pointer moves to the next register.
- R3: Load slots are numbered 0 to 3 and visited in this order: 0 empty low byte, 1 empty high byte, 2 full low byte, 3 full high byte.
- R4: After slot 3, the next qualifying write edge loads slot 0 again.
- R5: A write edge where load_n_i or wr_en_n_i is high changes no register and leaves the load pointer where it is, so a paused sequence resumes at the same slot.
- R6: empty_ofs_o is {slot 1, slot 0} and full_ofs_o is {slot 3, slot 2}, each kept to its low AW = clog2(DEPTH) bits.
- R7: On a rising rd_clk_i with rd_en_a_n_i, rd_en_b_n_i and load_n_i all low, rb_byte_o takes the byte in the slot under the readback pointer. That pointer then steps through the order of R3 and wraps after slot 3.
- R8: A read edge where any of rd_en_a_n_i, rd_en_b_n_i or load_n_i is high leaves rb_byte_o and the readback pointer unchanged.
- R9: Data input bits above bit 7 have no effect on any register.
- R10: Reset returns both the load pointer and the readback pointer to slot 0, even partway through a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock; loads happen on its rising edge |
| rd_clk_i | input | 1 | Read clock; readback happens on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | DATA_W | FIFO data input; bits 7:0 feed the offset bytes |
| wr_en_n_i | input | 1 | Active-low write enable |
| load_n_i | input | 1 | Active-low offset load/readback select |
| rd_en_a_n_i | input | 1 | First active-low read enable |
| rd_en_b_n_i | input | 1 | Second active-low read enable |
| rb_byte_o | output | 8 | Registered readback byte |
| empty_ofs_o | output | AW | Assembled almost-empty offset |
| full_ofs_o | output | AW | Assembled almost-full offset |

## Verification
If the load pointer slips, skips or fails to wrap, the next load shows up on the wrong offset output, or in the wrong half of the right one. That is visible at the first sample after the write edge. A pointer that moves during a pause shows up only when loading resumes, so the bench loads once more right after each pause. A wrong readback pointer shows as a byte out of order on rb_byte_o one read edge after the step. The scoreboard compares every qualified read against a byte model that the bench keeps itself.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam int unsigned OFS_W     = 2 * BYTE_W;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ofs_ring_ptr.sv
module ofs_ring_ptr #(
  parameter int unsigned N = 4,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] ptr_o
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (step_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ofs_byte_bank.sv
module ofs_byte_bank
  import flag_ofs_pkg::*;
#(
  parameter logic [OFS_W-1:0] EMPTY_DEF = OFS_W'(7),
  parameter logic [OFS_W-1:0] FULL_DEF  = OFS_W'(7)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [SLOT_W-1:0]                 sel_i,
  input  byte_t                             wdata_i,
  output logic [NUM_SLOTS-1:0][BYTE_W-1:0]  bytes_o
);
  function automatic byte_t slot_default(input int unsigned s);
    logic [OFS_W-1:0] ofs;
    ofs = (s < NUM_SLOTS / 2) ? EMPTY_DEF : FULL_DEF;
    return (s % 2 == 0) ? ofs[BYTE_W-1:0] : ofs[OFS_W-1:BYTE_W];
  endfunction

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam byte_t DEF = slot_default(s);
    byte_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= DEF;
      else if (we_i && sel_i == SLOT_W'(s))    q <= wdata_i;
    end
    assign bytes_o[s] = q;
  end
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
  import flag_ofs_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              step_i,
  input  logic [SLOT_W-1:0]                 sel_i,
  input  logic [NUM_SLOTS-1:0][BYTE_W-1:0]  bytes_i,
  output byte_t                             rb_o
);
  byte_t rb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rb_q <= '0;
    else if (step_i) rb_q <= bytes_i[sel_i];
  end

  assign rb_o = rb_q;
endmodule

// File: rtl/flag_offset_seq.sv
module flag_offset_seq
  import flag_ofs_pkg::*;
#(
  parameter int unsigned      DEPTH     = 1024,
  parameter int unsigned      DATA_W    = 9,
  parameter logic [OFS_W-1:0] EMPTY_DEF = OFS_W'(7),
  parameter logic [OFS_W-1:0] FULL_DEF  = OFS_W'(7),
  localparam int unsigned     AW        = $clog2(DEPTH)
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wr_en_n_i,
  input  logic              load_n_i,
  input  logic              rd_en_a_n_i,
  input  logic              rd_en_b_n_i,
  output logic [7:0]        rb_byte_o,
  output logic [AW-1:0]     empty_ofs_o,
  output logic [AW-1:0]     full_ofs_o
);
  logic                             load_ok;
  logic                             read_ok;
  logic [SLOT_W-1:0]                wr_ptr;
  logic [SLOT_W-1:0]                rd_ptr;
  logic [NUM_SLOTS-1:0][BYTE_W-1:0] bank_q;
  byte_t                            wr_byte;
  logic [OFS_W-1:0]                 empty_wide;
  logic [OFS_W-1:0]                 full_wide;

  assign load_ok = !load_n_i && !wr_en_n_i;
  assign read_ok = !load_n_i && !rd_en_a_n_i && !rd_en_b_n_i;
  assign wr_byte = BYTE_W'(data_i);  // upper data bits are not part of any offset

  ofs_ring_ptr #(.N(NUM_SLOTS)) u_wr_ptr (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .step_i (load_ok),
    .ptr_o  (wr_ptr)
  );

  ofs_ring_ptr #(.N(NUM_SLOTS)) u_rd_ptr (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .step_i (read_ok),
    .ptr_o  (rd_ptr)
  );

  ofs_byte_bank #(
    .EMPTY_DEF (EMPTY_DEF),
    .FULL_DEF  (FULL_DEF)
  ) u_bank (
    .clk_i   (wr_clk_i),
    .rst_ni  (rst_ni),
    .we_i    (load_ok),
    .sel_i   (wr_ptr),
    .wdata_i (wr_byte),
    .bytes_o (bank_q)
  );

  ofs_readback u_rb (
    .clk_i   (rd_clk_i),
    .rst_ni  (rst_ni),
    .step_i  (read_ok),
    .sel_i   (rd_ptr),
    .bytes_i (bank_q),
    .rb_o    (rb_byte_o)
  );

  assign empty_wide  = {bank_q[SLOT_EMPTY_HI], bank_q[SLOT_EMPTY_LO]};
  assign full_wide   = {bank_q[SLOT_FULL_HI],  bank_q[SLOT_FULL_LO]};
  assign empty_ofs_o = empty_wide[AW-1:0];
  assign full_ofs_o  = full_wide[AW-1:0];
endmodule

// File: rtl/flag_offset_seq_chk.sv
module flag_offset_seq_chk
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned AW     = 10
) (
  input logic                             wr_clk_i,
  input logic                             rd_clk_i,
  input logic                             rst_ni,
  input logic [DATA_W-1:0]                data_i,
  input logic                             wr_en_n_i,
  input logic                             load_n_i,
  input logic                             rd_en_a_n_i,
  input logic                             rd_en_b_n_i,
  input logic [SLOT_W-1:0]                wr_ptr,
  input logic [SLOT_W-1:0]                rd_ptr,
  input logic [NUM_SLOTS-1:0][BYTE_W-1:0] bank_q,
  input logic [7:0]                       rb_byte_o,
  input logic [AW-1:0]                    empty_ofs_o,
  input logic [AW-1:0]                    full_ofs_o
);
  logic ld, rd;
  assign ld = !load_n_i && !wr_en_n_i;
  assign rd = !load_n_i && !rd_en_a_n_i && !rd_en_b_n_i;

  p_load_value_r2: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    ld |=> bank_q[$past(wr_ptr)] == BYTE_W'($past(data_i)));

  p_ptr_step_r4: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    ld |=> wr_ptr == SLOT_W'($past(wr_ptr) + 1'b1));

  p_ptr_hold_r5: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !ld |=> $stable(wr_ptr));

  p_bank_hold_r5: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !ld |=> $stable(empty_ofs_o) && $stable(full_ofs_o));

  p_rb_step_r7: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd |=> rd_ptr == SLOT_W'($past(rd_ptr) + 1'b1));

  p_rb_hold_r8: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rb_byte_o) && $stable(rd_ptr));
endmodule

bind flag_offset_seq flag_offset_seq_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .wr_clk_i    (wr_clk_i),
  .rd_clk_i    (rd_clk_i),
  .rst_ni      (rst_ni),
  .data_i      (data_i),
  .wr_en_n_i   (wr_en_n_i),
  .load_n_i    (load_n_i),
  .rd_en_a_n_i (rd_en_a_n_i),
  .rd_en_b_n_i (rd_en_b_n_i),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .bank_q      (bank_q),
  .rb_byte_o   (rb_byte_o),
  .empty_ofs_o (empty_ofs_o),
  .full_ofs_o  (full_ofs_o)
);

// File: tb/sim_flag_offset_seq.sv
module sim_flag_offset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;
  localparam int DATA_W     = 9;
  localparam int AW         = $clog2(DEPTH);
  localparam logic [15:0] MASK = 16'((32'd1 << AW) - 1);

  logic              wclk, rclk, rst_ni;
  logic [DATA_W-1:0] data;
  logic              wen_n, load_n, ren_a_n, ren_b_n;
  logic [7:0]        rb;
  logic [AW-1:0]     e_ofs, f_ofs;

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  logic [7:0] m [4];
  int   wp, rp;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;
  logic rd_seen;

  flag_offset_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .wr_clk_i(wclk), .rd_clk_i(rclk), .rst_ni(rst_ni), .data_i(data),
    .wr_en_n_i(wen_n), .load_n_i(load_n), .rd_en_a_n_i(ren_a_n), .rd_en_b_n_i(ren_b_n),
    .rb_byte_o(rb), .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs)
  );

  initial begin wclk = 0; forever #(CLK_PERIOD/2) wclk = ~wclk; end
  initial begin rclk = 0; #2; forever #(CLK_PERIOD/2) rclk = ~rclk; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_empty();
    return 32'({m[1], m[0]} & MASK);
  endfunction
  function automatic logic [31:0] exp_full();
    return 32'({m[3], m[2]} & MASK);
  endfunction

  task automatic model_reset();
    m[0] = 8'd7; m[1] = 8'd0; m[2] = 8'd7; m[3] = 8'd0;
    wp = 0; rp = 0;
  endtask

  task automatic idle();
    wen_n = 1; load_n = 1; ren_a_n = 1; ren_b_n = 1;
    @(negedge wclk);
  endtask

  task automatic load(input logic [DATA_W-1:0] d);
    data = d; load_n = 0; wen_n = 0; ren_a_n = 1; ren_b_n = 1;
    @(negedge wclk);
    m[wp] = d[7:0]; wp = (wp + 1) % 4;
    load_n = 1; wen_n = 1;
  endtask

  // driver: push expected readback byte, monitor pops it
  task automatic readback();
    exp_q.push_back(m[rp]); rp = (rp + 1) % 4;
    load_n = 0; wen_n = 1; ren_a_n = 0; ren_b_n = 0;
    @(negedge wclk);
    load_n = 1; ren_a_n = 1; ren_b_n = 1;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge wclk);
    chk("R1 empty during reset", 32'(e_ofs), 32'd7);
    chk("R1 full during reset", 32'(f_ofs), 32'd7);
    rst_ni = 1; model_reset();
    @(negedge wclk);
  endtask

  always @(posedge rclk) rd_seen <= rst_ni && !ren_a_n && !ren_b_n && !load_n;

  always @(negedge wclk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("R7 unexpected read", 32'd1, 32'd0);
      else begin
        exp_b = exp_q.pop_front();
        chk("R7 readback byte", 32'(rb), 32'(exp_b));
      end
    end
  end

  initial begin
    rst_ni = 0; data = '0; wen_n = 1; load_n = 1; ren_a_n = 1; ren_b_n = 1;
    model_reset();
    repeat (3) @(negedge wclk);
    rst_ni = 1;
    @(negedge wclk);
    chk("R1 empty after reset", 32'(e_ofs), 32'd7);
    chk("R1 full after reset", 32'(f_ofs), 32'd7);
    chk("R1 readback after reset", 32'(rb), 32'd0);

    // R7: readback of defaults, then wrap on the fifth read
    repeat (5) readback();
    idle();

    // R2/R3/R9: one byte per slot, bit 8 set on some
    load(9'h134); chk("R2 empty low byte", 32'(e_ofs), 32'h034);
    load(9'h102); chk("R3 empty high byte", 32'(e_ofs), 32'h234);
    chk("R9 bit8 ignored", 32'(e_ofs), exp_empty());
    load(9'h0C5); chk("R3 full low byte", 32'(f_ofs), 32'h3C5 & 32'h0FF | 32'h000);
    load(9'h103); chk("R6 full assembled", 32'(f_ofs), 32'h3C5);
    chk("R3 empty untouched by full loads", 32'(e_ofs), 32'h234);

    // R4: fifth load wraps to empty low byte; R6 truncation of high byte
    load(9'h011); chk("R4 wrap to empty low", 32'(e_ofs), 32'h211);
    load(9'h0FD); chk("R6 high byte cut to AW", 32'(e_ofs), 32'h111);
    chk("R6 model agrees", 32'(e_ofs), exp_empty());

    // R5: pause with either control high, then resume at full low byte
    data = 9'h0AA; load_n = 1; wen_n = 0; @(negedge wclk);
    data = 9'h0BB; load_n = 0; wen_n = 1; @(negedge wclk);
    wen_n = 1; load_n = 1;
    chk("R5 empty held on pause", 32'(e_ofs), 32'h111);
    chk("R5 full held on pause", 32'(f_ofs), 32'h3C5);
    load(9'h040); chk("R5 resume at full low", 32'(f_ofs), 32'h340);
    chk("R5 full model", 32'(f_ofs), exp_full());

    // R8: unqualified read edges hold the readback output
    exp_b = rb;
    load_n = 0; ren_a_n = 0; ren_b_n = 1; @(negedge wclk);
    chk("R8 hold ren_b high", 32'(rb), 32'(exp_b));
    load_n = 1; ren_a_n = 0; ren_b_n = 0; @(negedge wclk);
    chk("R8 hold load high", 32'(rb), 32'(exp_b));
    ren_a_n = 1; ren_b_n = 1;
    // R7: pointer continues from where it stood
    repeat (4) readback();
    idle();

    // R10: reset partway through a load sequence
    load(9'h055);
    load(9'h066);
    do_reset();
    chk("R1 empty after mid reset", 32'(e_ofs), 32'd7);
    chk("R1 full after mid reset", 32'(f_ofs), 32'd7);
    chk("R1 readback cleared", 32'(rb), 32'd0);
    load(9'h077); chk("R10 load pointer back at empty low", 32'(e_ofs), 32'h077);
    chk("R10 full untouched", 32'(f_ofs), 32'd7);
    readback(); idle();  // R10: readback pointer at slot 0 gives 0x77
    idle();
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule